// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the programmable registers of a single DMA channel that moves data between memory and a device on a 32-bit processor bus. It carries one control/status word and six 32-bit buffer registers: the current pointer, the limit, the start and stop addresses, the initial value for the current pointer, and a size word. Software reaches them through a simple request/write/address/byte-enable interface. Only full-word accesses take effect.

The control/status word does not store what is written to it. Each written bit is a command that sets, clears or resets status flags, and a read returns the flags. The channel's datapath drives a one-cycle `xfer_done` pulse when a transfer ends. While the channel is enabled, that pulse latches a complete flag. The enable, direction, single-update and complete flags are also driven out as plain outputs so the datapath can follow them.

Top module: `dmach_regfile`

## Requirements
- R1: While `rst_n` is low and after it is released, all four status flags are 0, every buffer register reads 0, and `bus_rdata` is 0.
- R2: The control/status word sits at offset 0x0000. A read of it returns enable in bit 0, single-update in bit 1, complete in bit 3 and device-to-memory direction in bit 4. All other bits read as 0.
- R3: A full-word write to offset 0x0000 works as follows, and a set flag is not cleared by a later write that lacks its command bit:
  - bit 0 set sets enable;
  - bit 1 set sets single-update;
  - bit 4 set sets direction.
- R4: A full-word write to offset 0x0000 with bit 2 set clears the complete flag and no other flag.
- R5: A full-word write to offset 0x0000 with bit 3 set clears enable, single-update, complete and direction together. This overrides any set bit in the same word and any `xfer_done` in the same cycle. The buffer registers keep their values.
- R6: An `xfer_done` pulse sets complete only in a cycle where enable is already 1. If a clear-complete command lands in the same cycle, the pulse wins.
- R7: The buffer registers sit at these offsets and each reads back the full 32-bit value last written to it:

  | Register | Offset |
  |---|---|
  | current pointer | 0x4000 |
  | limit | 0x4004 |
  | start | 0x4008 |
  | stop | 0x400C |
  | initial pointer | 0x4200 |
  | size | 0x4204 |

- R8: An access whose byte enable `bus_be` is not all ones (4'hF) has these effects:
  - as a write, it changes no register and no flag;
  - as a read, it returns 0.
- R9: A read from any offset not named in R2 or R7 returns 0. A write to such an offset changes nothing.
- R10: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 15 | Byte offset inside the channel |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data or command word |
| bus_rdata | output | 32 | Registered read data |
| xfer_done | input | 1 | Transfer-finished pulse from the datapath |
| chan_en | output | 1 | Enable flag |
| chan_supd | output | 1 | Single-update flag |
| chan_dir | output | 1 | Device-to-memory direction flag |
| chan_complete | output | 1 | Complete flag |

## Verification
A wrong flag appears at once on the `chan_*` outputs, one cycle after the command or pulse that caused it. It also appears in the status word on the next read of offset 0. A buffer register that holds a wrong value, or was corrupted by a command, narrow write or unmapped write, shows nothing until it is read. The bench therefore interleaves reads of every offset among random writes, so that corruption is seen within a few operations. A decode that misses or hits the wrong entry shows as a wrong or nonzero `bus_rdata` one cycle after the read.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int NPTR = 6;

  // Command / status bit positions in the control word
  localparam int CMD_SET_EN   = 0;
  localparam int CMD_SET_SUPD = 1;
  localparam int CMD_CLR_CMPL = 2;
  localparam int CMD_RESET    = 3;
  localparam int CMD_DEV2MEM  = 4;
  localparam int ST_EN        = 0;
  localparam int ST_SUPD      = 1;
  localparam int ST_CMPL      = 3;
  localparam int ST_DIR       = 4;

  localparam logic [15:0] CSR_OFS = 16'h0000;

  typedef struct packed {
    logic en;
    logic supd;
    logic cmpl;
    logic dir;
  } chan_flags_t;

  function automatic logic [15:0] ptr_offset(input int idx);
    case (idx)
      0: ptr_offset = 16'h4000;
      1: ptr_offset = 16'h4004;
      2: ptr_offset = 16'h4008;
      3: ptr_offset = 16'h400C;
      4: ptr_offset = 16'h4200;
      default: ptr_offset = 16'h4204;
    endcase
  endfunction
endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BE_W   = 4
) (
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic              csr_wr,
  output logic              csr_rd,
  output logic [NPTR-1:0]   ptr_wr,
  output logic [NPTR-1:0]   ptr_rd,
  output logic              rd_any
);
  logic full_word;
  logic [NPTR-1:0] ptr_hit;
  logic csr_hit;

  assign full_word = (be == {BE_W{1'b1}});
  assign csr_hit   = (addr == CSR_OFS[ADDR_W-1:0]);

  for (genvar i = 0; i < NPTR; i++) begin : g_hit
    assign ptr_hit[i] = (addr == ptr_offset(i)[ADDR_W-1:0]);
    assign ptr_wr[i]  = req && wr && full_word && ptr_hit[i];
    assign ptr_rd[i]  = req && !wr && full_word && ptr_hit[i];
  end

  assign csr_wr = req && wr && full_word && csr_hit;
  assign csr_rd = req && !wr && full_word && csr_hit;
  assign rd_any = req && !wr;
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [DATA_W-1:0] cmd,
  input  logic              done,
  output chan_flags_t       flags
);
  chan_flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (csr_wr) begin
      if (cmd[CMD_SET_EN])   flags_d.en   = 1'b1;
      if (cmd[CMD_SET_SUPD]) flags_d.supd = 1'b1;
      if (cmd[CMD_DEV2MEM])  flags_d.dir  = 1'b1;
      if (cmd[CMD_CLR_CMPL]) flags_d.cmpl = 1'b0;
    end
    if (done && flags_q.en) flags_d.cmpl = 1'b1;
    if (csr_wr && cmd[CMD_RESET]) flags_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/dmach_ptrs.sv
module dmach_ptrs
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPTR-1:0]             wr_en,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NPTR-1:0][DATA_W-1:0] value
);
  for (genvar i = 0; i < NPTR; i++) begin : g_reg
    logic [DATA_W-1:0] q, d;
    always_comb d = wr_en[i] ? wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign value[i] = q;
  end
endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              xfer_done,
  output logic              chan_en,
  output logic              chan_supd,
  output logic              chan_dir,
  output logic              chan_complete
);
  logic csr_wr, csr_rd, rd_any;
  logic [NPTR-1:0] ptr_wr, ptr_rd;
  logic [NPTR-1:0][DATA_W-1:0] ptr_val;
  chan_flags_t flags;
  logic [DATA_W-1:0] status_word, rd_mux, rdata_q, rdata_d;

  dmach_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .req(bus_req), .wr(bus_wr), .addr(bus_addr), .be(bus_be),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .ptr_wr(ptr_wr), .ptr_rd(ptr_rd),
    .rd_any(rd_any)
  );

  dmach_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .cmd(bus_wdata),
    .done(xfer_done), .flags(flags)
  );

  dmach_ptrs #(.DATA_W(DATA_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr), .wdata(bus_wdata),
    .value(ptr_val)
  );

  always_comb begin
    status_word          = '0;
    status_word[ST_EN]   = flags.en;
    status_word[ST_SUPD] = flags.supd;
    status_word[ST_CMPL] = flags.cmpl;
    status_word[ST_DIR]  = flags.dir;
  end

  always_comb begin
    rd_mux = csr_rd ? status_word : '0;
    for (int i = 0; i < NPTR; i++) begin
      if (ptr_rd[i]) rd_mux = rd_mux | ptr_val[i];
    end
  end

  always_comb rdata_d = rd_any ? rd_mux : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata     = rdata_q;
  assign chan_en       = flags.en;
  assign chan_supd     = flags.supd;
  assign chan_dir      = flags.dir;
  assign chan_complete = flags.cmpl;
endmodule

// File: rtl/dmach_regfile_chk.sv
module dmach_regfile_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              xfer_done,
  input logic              chan_en,
  input logic              chan_supd,
  input logic              chan_dir,
  input logic              chan_complete
);
  logic ctl_write, rst_cmd;
  assign ctl_write = bus_req && bus_wr && (bus_be == {BE_W{1'b1}}) && (bus_addr == '0);
  assign rst_cmd   = ctl_write && bus_wdata[3];

  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && chan_en && !rst_cmd) |=> chan_complete);

  a_r6_complete_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_complete && !(xfer_done && chan_en)) |=> !chan_complete);

  a_r4_clear_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && bus_wdata[2] && !(xfer_done && chan_en)) |=> !chan_complete);

  a_r5_reset_all: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> !(chan_en || chan_supd || chan_dir || chan_complete));

  a_r3_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !rst_cmd) |=> chan_en);

  a_r3_dir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_dir && !rst_cmd) |=> chan_dir);

  a_r8_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_be != {BE_W{1'b1}}) |=> (bus_rdata == '0));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind dmach_regfile dmach_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .xfer_done(xfer_done), .chan_en(chan_en),
  .chan_supd(chan_supd), .chan_dir(chan_dir), .chan_complete(chan_complete)
);

// File: tb/dmach_regfile_tb.sv
module dmach_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic req, wr, done;
  logic [AW-1:0] addr;
  logic [3:0] be;
  logic [31:0] wdata, rdata;
  logic c_en, c_supd, c_dir, c_cmpl;

  int n_checks = 0;
  int n_errors = 0;

  // Bench model
  logic m_en, m_supd, m_cmpl, m_dir;
  logic [31:0] m_ptr [6];
  logic [31:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmach_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_wr(wr), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata), .xfer_done(done),
    .chan_en(c_en), .chan_supd(c_supd), .chan_dir(c_dir), .chan_complete(c_cmpl)
  );

  function automatic logic [14:0] ofs_of(input int i);
    case (i)
      0: return 15'h4000; 1: return 15'h4004; 2: return 15'h4008;
      3: return 15'h400C; 4: return 15'h4200; default: return 15'h4204;
    endcase
  endfunction

  function automatic int idx_of(input logic [14:0] a);
    for (int i = 0; i < 6; i++) if (ofs_of(i) == a) return i;
    return -1;
  endfunction

  function automatic logic [31:0] status_exp();
    return {27'd0, m_dir, m_cmpl, 1'b0, m_supd, m_en};
  endfunction

  function automatic logic [31:0] read_exp(input logic [14:0] a, input logic [3:0] b);
    if (b != 4'hF) return 32'd0;
    if (a == 15'h0) return status_exp();
    if (idx_of(a) >= 0) return m_ptr[idx_of(a)];
    return 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [14:0] a,
                      input logic [3:0] b, input logic [31:0] d, input logic dn,
                      input string tag);
    logic full;
    logic pre_en;
    req = r; wr = w; addr = a; be = b; wdata = d; done = dn;
    full = (b == 4'hF);
    pre_en = m_en;
    if (r && !w) m_rd = read_exp(a, b);
    @(posedge clk); #1;
    if (r && w && full && a == 15'h0) begin
      if (d[0]) m_en = 1'b1;
      if (d[1]) m_supd = 1'b1;
      if (d[4]) m_dir = 1'b1;
      if (d[2]) m_cmpl = 1'b0;
    end
    if (dn && pre_en) m_cmpl = 1'b1;
    if (r && w && full && a == 15'h0 && d[3]) begin
      m_en = 0; m_supd = 0; m_cmpl = 0; m_dir = 0;
    end
    if (r && w && full && idx_of(a) >= 0) m_ptr[idx_of(a)] = d;
    req = 0; wr = 0; done = 0;
    check({tag, " flags"}, {28'd0, c_dir, c_cmpl, c_supd, c_en},
          {28'd0, m_dir, m_cmpl, m_supd, m_en});
    check({tag, " rdata"}, rdata, m_rd);
  endtask

  task automatic rd(input logic [14:0] a, input string tag);
    step(1, 0, a, 4'hF, 32'h0, 0, tag);
  endtask

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    req = 0; wr = 0; addr = '0; be = 4'hF; wdata = '0; done = 0;
    m_en = 0; m_supd = 0; m_cmpl = 0; m_dir = 0; m_rd = 0;
    for (int i = 0; i < 6; i++) m_ptr[i] = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", {28'd0, c_dir, c_cmpl, c_supd, c_en}, 32'd0);
    check("R1 reset rdata", rdata, 32'd0);
    rst_n = 1;
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) rd(ofs_of(i), "R1 ptr reset");
    rd(15'h0, "R2 status reset");

    // R7 pointer writes/readback
    for (int i = 0; i < 6; i++) step(1, 1, ofs_of(i), 4'hF, 32'hA5000000 + i, 0, "R7 write");
    for (int i = 0; i < 6; i++) rd(ofs_of(i), "R7 readback");
    // R3 set commands, sticky
    step(1, 1, 15'h0, 4'hF, 32'h11, 0, "R3 set en+dir");
    step(1, 1, 15'h0, 4'hF, 32'h02, 0, "R3 set supd");
    step(1, 1, 15'h0, 4'hF, 32'h00, 0, "R3 sticky");
    rd(15'h0, "R2 status layout");
    // R6 done sets complete; done wins over clear
    step(0, 0, 15'h0, 4'hF, 32'h0, 1, "R6 done");
    step(1, 1, 15'h0, 4'hF, 32'h04, 1, "R6 done beats clear");
    // R4 clear only complete
    step(1, 1, 15'h0, 4'hF, 32'h04, 0, "R4 clear cmpl");
    // R8 narrow accesses
    step(1, 1, 15'h0, 4'h7, 32'h08, 0, "R8 narrow csr write");
    step(1, 1, 15'h4000, 4'h1, 32'hDEAD, 0, "R8 narrow ptr write");
    step(1, 0, 15'h4000, 4'h3, 32'h0, 0, "R8 narrow read");
    rd(15'h4000, "R8 ptr intact");
    // R9 unmapped
    step(1, 1, 15'h4010, 4'hF, 32'hFFFF, 0, "R9 unmapped write");
    step(1, 0, 15'h4010, 4'hF, 32'h0, 0, "R9 unmapped read");
    // R5 reset command beats set and done, pointers kept
    step(0, 0, 15'h0, 4'hF, 32'h0, 1, "R6 done again");
    step(1, 1, 15'h0, 4'hF, 32'h1B, 1, "R5 reset cmd");
    for (int i = 0; i < 6; i++) rd(ofs_of(i), "R5 ptr kept");
    // R6 done ignored when disabled
    step(0, 0, 15'h0, 4'hF, 32'h0, 1, "R6 done disabled");
    // R10 hold
    step(0, 0, 15'h0, 4'hF, 32'h0, 0, "R10 hold");

    // Random phase
    for (int n = 0; n < 1500; n++) begin
      logic [14:0] a;
      logic [3:0] b;
      int k;
      k = $urandom_range(0, 9);
      if (k < 6) a = ofs_of(k);
      else if (k < 8) a = 15'h0;
      else a = 15'($urandom_range(0, 32767)) & 15'h7FFC;
      b = ($urandom_range(0, 4) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      step($urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, a, b,
           (a == 15'h0) ? ($urandom_range(0, 3) == 0 ? 32'h8 : 32'($urandom_range(0, 23)))
                        : $urandom,
           $urandom_range(0, 3) == 0, "R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule